// File: doc/BRIEF.md
# Frequency Lock Detector with Hysteresis

This block decides whether a local clock, divided down to the same nominal rate as a reference clock, runs at the same frequency as that reference. Both clocks reach it as single-cycle enable pulses in one system clock domain. The block counts local pulses while a fixed number of reference pulses goes by, which is the measurement window. It then compares the signed surplus or deficit with thresholds given in counts.

The lock flag uses hysteresis with two thresholds. A locked detector lets go only when the error grows past a wide drop threshold, about 488 ppm. An unlocked detector locks again only when the error falls below a narrower relock threshold. A select input picks that threshold: about 122 ppm when high and about 30 ppm when low. With a window of 2^15 reference pulses these thresholds come to 16, 4 and 1 counts. The measured difference is also given as an output, so that acquisition can be watched.

Top module: `fld_lock_det`

## Requirements
- R1: After reset, lock_o is 0 and diff_o is 0.
- R2: A window closes on every 2^WIN_LOG2-th reference enable pulse. When it closes, diff_o takes the two's-complement value (local pulses counted in that window, including one in the closing cycle) minus 2^WIN_LOG2. diff_o keeps its value between window closings.
- R3: The first window after reset is thrown away. diff_o stays 0 and lock_o stays 0 through its closing.
- R4: lock_o changes only in the cycle after a window closing.
- R5: If lock_o is 1 and the window's |diff| is greater than DROP_CNT, lock_o becomes 0.
- R6: If lock_o is 0 and |diff| is less than the relock threshold, lock_o becomes 1. The relock threshold is RLK_HI_CNT when tight_sel_i is 1 and RLK_LO_CNT when tight_sel_i is 0. tight_sel_i is sampled at the decision.
- R7: If |diff| is no less than the relock threshold and no greater than DROP_CNT, lock_o keeps its value.
- R8: tight_sel_i has no effect while lock_o is 1.
- R9: The local pulse counter saturates at 2^(WIN_LOG2+1)-1, so diff_o never wraps. With local pulses in every cycle and reference pulses in every other cycle, diff_o reads 2^WIN_LOG2-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_en_i | input | 1 | Reference clock enable pulse |
| loc_en_i | input | 1 | Divided local clock enable pulse |
| tight_sel_i | input | 1 | Relock threshold select: 1 picks the looser relock count, 0 the tighter |
| lock_o | output | 1 | Frequency lock flag, active high |
| diff_o | output | WIN_LOG2+2 | Signed count difference of the last kept window |

## Verification
diff_o is registered on the edge that closes a window. lock_o follows one edge later, because the decision is made from the registered difference. The bench counts its own reference pulses. It records the edge on which each window closes and accepts a change of lock_o only when seen at the falling edge right after the closing edge plus one. Every other result is sampled after a settling time of three full windows. By then the window that mixed the old and new rates has passed, and at least one whole window at the new ratio has been judged.

// File: rtl/fld_pkg.sv
package fld_pkg;

  typedef enum logic {
    ST_UNLOCKED = 1'b0,
    ST_LOCKED   = 1'b1
  } lock_st_e;

  // Threshold in counts for an error of 2^-shift over a 2^win_log2 window.
  function automatic int unsigned ppm_to_cnt(int unsigned win_log2, int unsigned shift);
    return (win_log2 > shift) ? (32'd1 << (win_log2 - shift)) : 32'd1;
  endfunction

endpackage

// File: rtl/fld_win_cnt.sv
module fld_win_cnt #(
  parameter int unsigned WIN_LOG2 = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_en_i,
  output logic win_end_o,
  output logic commit_o,
  output logic dec_en_o
);

  logic [WIN_LOG2-1:0] ref_cnt_q;
  logic                seen_q;
  logic                dec_q;

  assign win_end_o = ref_en_i && (&ref_cnt_q);
  // first closing after reset only arms the detector
  assign commit_o  = win_end_o && seen_q;
  assign dec_en_o  = dec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_cnt_q <= '0;
      seen_q    <= 1'b0;
      dec_q     <= 1'b0;
    end else begin
      if (ref_en_i) ref_cnt_q <= ref_cnt_q + 1'b1;
      if (win_end_o) seen_q <= 1'b1;
      dec_q <= commit_o;
    end
  end

  a_r3_first_window_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> !dec_q);

  a_r2_single_decision: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_q |=> !dec_q);

endmodule

// File: rtl/fld_loc_cnt.sv
module fld_loc_cnt #(
  parameter int unsigned WIN_LOG2 = 15,
  localparam int unsigned CW      = WIN_LOG2 + 1,
  localparam int unsigned DW      = WIN_LOG2 + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          loc_en_i,
  input  logic          win_end_i,
  input  logic          commit_i,
  output logic [DW-1:0] diff_o
);

  localparam int unsigned WIN_LEN = 32'd1 << WIN_LOG2;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_inc;
  logic [DW-1:0] diff_q;

  // saturate rather than wrap on a grossly fast local clock
  assign cnt_inc = (&cnt_q) ? cnt_q : cnt_q + CW'(loc_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      diff_q <= '0;
    end else begin
      cnt_q <= win_end_i ? '0 : cnt_inc;
      if (commit_i) diff_q <= {1'b0, cnt_inc} - DW'(WIN_LEN);
    end
  end

  assign diff_o = diff_q;

  a_r9_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(win_end_i) |-> cnt_q >= $past(cnt_q));

  a_r2_diff_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(commit_i) |-> $stable(diff_q));

endmodule

// File: rtl/fld_judge.sv
module fld_judge
  import fld_pkg::*;
#(
  parameter int unsigned DW         = 17,
  parameter int unsigned DROP_CNT   = 16,
  parameter int unsigned RLK_HI_CNT = 4,
  parameter int unsigned RLK_LO_CNT = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dec_en_i,
  input  logic [DW-1:0] diff_i,
  input  logic          tight_sel_i,
  output logic          lock_o
);

  localparam logic [DW-1:0] DROP_TH = DW'(DROP_CNT);
  localparam logic [DW-1:0] HI_TH   = DW'(RLK_HI_CNT);
  localparam logic [DW-1:0] LO_TH   = DW'(RLK_LO_CNT);

  lock_st_e      st_q, st_d;
  logic [DW-1:0] mag;
  logic [DW-1:0] rlk_th;

  assign mag    = diff_i[DW-1] ? (~diff_i + 1'b1) : diff_i;
  assign rlk_th = tight_sel_i ? HI_TH : LO_TH;

  always_comb begin
    st_d = st_q;
    if (dec_en_i) begin
      unique case (st_q)
        ST_LOCKED:   if (mag > DROP_TH) st_d = ST_UNLOCKED;
        ST_UNLOCKED: if (mag < rlk_th)  st_d = ST_LOCKED;
        default:     st_d = ST_UNLOCKED;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_UNLOCKED;
    else         st_q <= st_d;
  end

  assign lock_o = (st_q == ST_LOCKED);

  a_r4_change_at_decision: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o != $past(lock_o)) |-> $past(dec_en_i));

  a_r5_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_en_i && lock_o && mag > DROP_TH) |=> !lock_o);

  a_r6_relock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_en_i && !lock_o && mag < rlk_th) |=> lock_o);

  a_r7_hold_band: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_en_i && mag >= rlk_th && mag <= DROP_TH) |=> $stable(lock_o));

  a_r8_sel_ignored_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_en_i && lock_o && mag <= DROP_TH) |=> lock_o);

endmodule

// File: rtl/fld_lock_det.sv
module fld_lock_det #(
  parameter int unsigned WIN_LOG2   = 15,
  parameter int unsigned DROP_CNT   = fld_pkg::ppm_to_cnt(WIN_LOG2, 11),
  parameter int unsigned RLK_HI_CNT = fld_pkg::ppm_to_cnt(WIN_LOG2, 13),
  parameter int unsigned RLK_LO_CNT = fld_pkg::ppm_to_cnt(WIN_LOG2, 15),
  localparam int unsigned DW        = WIN_LOG2 + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ref_en_i,
  input  logic          loc_en_i,
  input  logic          tight_sel_i,
  output logic          lock_o,
  output logic [DW-1:0] diff_o
);

  logic win_end;
  logic commit;
  logic dec_en;

  fld_win_cnt #(.WIN_LOG2(WIN_LOG2)) u_win (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ref_en_i  (ref_en_i),
    .win_end_o (win_end),
    .commit_o  (commit),
    .dec_en_o  (dec_en)
  );

  fld_loc_cnt #(.WIN_LOG2(WIN_LOG2)) u_loc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .loc_en_i  (loc_en_i),
    .win_end_i (win_end),
    .commit_i  (commit),
    .diff_o    (diff_o)
  );

  fld_judge #(
    .DW         (DW),
    .DROP_CNT   (DROP_CNT),
    .RLK_HI_CNT (RLK_HI_CNT),
    .RLK_LO_CNT (RLK_LO_CNT)
  ) u_judge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dec_en_i    (dec_en),
    .diff_i      (diff_o),
    .tight_sel_i (tight_sel_i),
    .lock_o      (lock_o)
  );

  a_r1_unlocked_out_of_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(dec_en));

endmodule

// File: tb/sim_fld_lock_det.sv
`timescale 1ns/1ps
module sim_fld_lock_det;
  localparam int W   = 10;
  localparam int DW  = W + 2;
  localparam int WIN = 1 << W;
  localparam int SETTLE = 3 * 2 * WIN + 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_en = 1'b0;
  logic loc_en = 1'b0;
  logic sel = 1'b1;
  logic lock;
  logic [DW-1:0] diff;

  int checks = 0;
  int errors = 0;
  int d_set = 0;
  bit full_loc = 1'b0;
  bit done = 1'b0;
  logic [15:0] racc = '0;
  logic [15:0] lacc = '0;
  longint cyc = 0;
  longint close_at = -10;
  int rpulses = 0;
  logic lock_prev = 1'b0;

  fld_lock_det #(
    .WIN_LOG2(W), .DROP_CNT(16), .RLK_HI_CNT(4), .RLK_LO_CNT(1)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ref_en_i(ref_en), .loc_en_i(loc_en),
    .tight_sel_i(sel), .lock_o(lock), .diff_o(diff)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  // rate generators: reference every other cycle, local offset by d_set counts per window
  always @(negedge clk) begin
    logic [16:0] rs, ls;
    rs = {1'b0, racc} + 17'd32768;
    ls = {1'b0, lacc} + 17'(32768 + 32 * d_set);
    racc = rs[15:0];
    lacc = ls[15:0];
    ref_en <= rs[16];
    loc_en <= full_loc | ls[16];
    if (rs[16] && rst_n) begin
      rpulses++;
      if (rpulses % WIN == 0) close_at = cyc + 1;
    end
  end

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R4: lock may only move on the edge after a window closing edge
  always @(negedge clk) begin
    if (rst_n && lock !== lock_prev) chk("R4 lock change edge", cyc, close_at + 1);
    lock_prev = lock;
  end

  task automatic step(string req, int d, bit s, bit full, bit exp_lock, int exp_diff);
    @(negedge clk);
    d_set = d;
    sel = s;
    full_loc = full;
    repeat (SETTLE) @(negedge clk);
    chk({req, " lock"}, lock, exp_lock);
    chk({req, " diff"}, $signed(diff), exp_diff);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 180000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 reset lock", lock, 0);
    chk("R1 reset diff", $signed(diff), 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3000) @(negedge clk);
    chk("R3 first window lock", lock, 0);
    chk("R3 first window diff", $signed(diff), 0);
    repeat (1600) @(negedge clk);
    chk("R6 first lock sel=1", lock, 1);
    chk("R2 zero diff", $signed(diff), 0);

    step("R7 hold locked +10", 10, 1, 0, 1, 10);
    step("R7 hold locked -10", -10, 1, 0, 1, -10);
    step("R5 drop at 17", 17, 1, 0, 0, 17);
    step("R5 stay unlocked 20", 20, 1, 0, 0, 20);
    step("R7 hold unlocked 10", 10, 1, 0, 0, 10);
    step("R5 boundary 16 unlocked", 16, 1, 0, 0, 16);
    step("R6 sel=0 no relock at 3", 3, 0, 0, 0, 3);
    step("R6 sel=1 relock at 3", 3, 1, 0, 1, 3);
    step("R8 sel=0 while locked", -3, 0, 0, 1, -3);
    step("R7 boundary 16 locked", 16, 0, 0, 1, 16);
    step("R5 drop at -17", -17, 0, 0, 0, -17);
    step("R6 sel=0 no relock at -1", -1, 0, 0, 0, -1);
    step("R6 sel=0 relock at 0", 0, 0, 0, 1, 0);
    step("R9 saturated local count", 0, 0, 1, 0, WIN - 1);
    finish_run();
  end
endmodule